// File: doc/BRIEF.md
# Supervisory Call Key Validator

This block sits in front of a privileged firmware-service dispatcher. When the CPU raises a call strobe with a function code, the block latches that code and the stack pointer. It then reads a small parameter block from RAM at a fixed base address. That block holds two authorisation keys and a target block number. The call is accepted only when the first key holds the constant 3Ah and the second key equals the latched stack pointer plus 3, modulo 256.

After the check, the block dispatches to a stub service handler. Each handler's pass/fail outcome comes from an input vector. For read, write, erase and parameter-write functions, it also applies per-block protection bits, which are fixed inputs the CPU cannot alter. The outcome byte is written back over the first key's slot, and a one-cycle done pulse follows.

Two functions return data in that slot instead of a status code: table-read and checksum. A call with bad keys, or with an unknown function code, is fatal. The block writes 03h and stays halted until reset.

Top module: `svc_key_gate`

## Requirements
- R1: A call whose key at parameter offset 0 is not 3Ah writes 03h to offset 0, ends with done, and raises halted_o in the same cycle as done.
- R2: The key at offset 1 must equal (stack pointer latched at the call + 3) mod 256, so stack pointer FEh needs key 01h. Otherwise the call fails as in R1.
- R3: Each accepted call makes exactly one RAM write, always to the parameter base (offset 0).
- R4: The block number is read from parameter offset 2, and its low log2(NBLK) bits select a protection bit. Read (function 1) with its read-protect bit set gives 01h. Write (2), erase (3) and parameter-write (4) with their write-protect bit set give 01h. The protect bit of the other kind has no effect.
- R5: An unprotected function 1, 2 or 3 gives 04h when its stub_fail_i bit (indexed by function code) is set, and 00h otherwise. Function 4 gives 06h on fail and 00h on pass.
- R6: Function 7 (software reset without hardware reset) gives 02h.
- R7: Function 5 (table-read) writes the block byte XOR A5h. Function 6 (checksum) writes (key1 + key2 + block byte) mod 256. Neither writes a status code.
- R8: Function codes 0 and 8 to 15 with valid keys write 03h and raise halted_o.
- R9: While halted_o is high, calls are ignored: no RAM write and no done until reset.
- R10: done_o pulses for one cycle, in the cycle after the write cycle. A call strobe while a call is in progress is ignored.
- R11: After reset, done_o, ram_we_o and halted_o are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| call_i | input | 1 | Supervisory call strobe |
| func_i | input | 4 | Function code, latched with the call |
| sp_i | input | 8 | Stack pointer, latched with the call |
| ram_addr_o | output | AW | RAM address |
| ram_we_o | output | 1 | RAM write enable |
| ram_wdata_o | output | 8 | RAM write data (result byte) |
| ram_rdata_i | input | 8 | RAM read data, one cycle after the address |
| prot_rd_i | input | NBLK | Per-block read protection |
| prot_wr_i | input | NBLK | Per-block write/erase protection |
| stub_fail_i | input | 16 | Stub handler fail flag per function code |
| done_o | output | 1 | One-cycle completion pulse |
| halted_o | output | 1 | Sticky halt after a fatal call |

## Verification
The hardest state to reach from the ports is the sticky halt, followed by a further call that must leave RAM untouched. The bench gets there three ways: a wrong first key, a second key off by one from the stack-pointer rule, and an unknown function code. After each, it resets.

While halted, it issues a well-formed call and watches the write and done counters for many cycles. Protection cross-cases are reached by setting only the opposite kind of protect bit for the addressed block. The wrap of the stack-pointer rule is reached with stack pointer FEh.

// File: rtl/svc_key_pkg.sv
package svc_key_pkg;
  localparam int BYTE_W = 8;
  localparam int FN_W   = 4;
  localparam int NFUNC  = 1 << FN_W;

  localparam logic [BYTE_W-1:0] KEY1_VAL   = 8'h3A;
  localparam logic [BYTE_W-1:0] SP_KEY_OFF = 8'd3;
  localparam logic [BYTE_W-1:0] TABLE_MASK = 8'hA5;

  localparam logic [1:0] OFF_K1  = 2'd0;
  localparam logic [1:0] OFF_K2  = 2'd1;
  localparam logic [1:0] OFF_BLK = 2'd2;

  localparam logic [BYTE_W-1:0] RC_OK     = 8'h00;
  localparam logic [BYTE_W-1:0] RC_PROT   = 8'h01;
  localparam logic [BYTE_W-1:0] RC_SWRST  = 8'h02;
  localparam logic [BYTE_W-1:0] RC_FATAL  = 8'h03;
  localparam logic [BYTE_W-1:0] RC_VERIFY = 8'h04;
  localparam logic [BYTE_W-1:0] RC_PCSUM  = 8'h06;

  localparam logic [FN_W-1:0] FN_READ   = 4'd1;
  localparam logic [FN_W-1:0] FN_WRITE  = 4'd2;
  localparam logic [FN_W-1:0] FN_ERASE  = 4'd3;
  localparam logic [FN_W-1:0] FN_PWRITE = 4'd4;
  localparam logic [FN_W-1:0] FN_TABLE  = 4'd5;
  localparam logic [FN_W-1:0] FN_CSUM   = 4'd6;
  localparam logic [FN_W-1:0] FN_SWRST  = 4'd7;

  typedef enum logic [2:0] {
    S_IDLE, S_RK1, S_RK2, S_RBLK, S_EVAL, S_WRITE, S_DONE
  } seq_t;

  typedef enum logic [1:0] {PK_NONE, PK_READ, PK_WRITE} pkind_t;

  function automatic logic [BYTE_W-1:0] key2_for(input logic [BYTE_W-1:0] sp);
    return sp + SP_KEY_OFF;
  endfunction

  function automatic logic [BYTE_W-1:0] table_word(input logic [BYTE_W-1:0] b);
    return b ^ TABLE_MASK;
  endfunction

  function automatic logic [BYTE_W-1:0] csum_word(input logic [BYTE_W-1:0] a,
                                                  input logic [BYTE_W-1:0] b,
                                                  input logic [BYTE_W-1:0] c);
    return a + b + c;
  endfunction

  function automatic pkind_t kind_of(input logic [FN_W-1:0] fn);
    case (fn)
      FN_READ:                        return PK_READ;
      FN_WRITE, FN_ERASE, FN_PWRITE:  return PK_WRITE;
      default:                        return PK_NONE;
    endcase
  endfunction
endpackage

// File: rtl/svc_key_check.sv
module svc_key_check
  import svc_key_pkg::*;
(
  input  logic [BYTE_W-1:0] key1,
  input  logic [BYTE_W-1:0] key2,
  input  logic [BYTE_W-1:0] sp,
  output logic              key1_ok,
  output logic              key2_ok,
  output logic              keys_ok
);
  assign key1_ok = (key1 == KEY1_VAL);
  assign key2_ok = (key2 == key2_for(sp));
  assign keys_ok = key1_ok && key2_ok;
endmodule

// File: rtl/svc_prot_lookup.sv
module svc_prot_lookup
  import svc_key_pkg::*;
#(
  parameter int NBLK = 8,
  localparam int BLK_W = (NBLK > 1) ? $clog2(NBLK) : 1
)(
  input  logic [BLK_W-1:0] idx,
  input  logic [FN_W-1:0]  func,
  input  logic [NBLK-1:0]  prot_rd,
  input  logic [NBLK-1:0]  prot_wr,
  output logic             guarded,
  output logic             prot_hit
);
  logic [NBLK-1:0] rd_sel;
  logic [NBLK-1:0] wr_sel;
  pkind_t          kind;

  for (genvar g = 0; g < NBLK; g++) begin : g_blk
    assign rd_sel[g] = (idx == BLK_W'(g)) && prot_rd[g];
    assign wr_sel[g] = (idx == BLK_W'(g)) && prot_wr[g];
  end

  assign kind     = kind_of(func);
  assign guarded  = (kind != PK_NONE);
  assign prot_hit = ((kind == PK_READ) && (|rd_sel)) ||
                    ((kind == PK_WRITE) && (|wr_sel));
endmodule

// File: rtl/svc_dispatch.sv
module svc_dispatch
  import svc_key_pkg::*;
(
  input  logic              keys_ok,
  input  logic [FN_W-1:0]   func,
  input  logic              prot_hit,
  input  logic              stub_fail,
  input  logic [BYTE_W-1:0] key1,
  input  logic [BYTE_W-1:0] key2,
  input  logic [BYTE_W-1:0] blk,
  output logic [BYTE_W-1:0] result,
  output logic              fatal
);
  always_comb begin
    result = RC_FATAL;
    fatal  = 1'b1;
    if (keys_ok) begin
      fatal = 1'b0;
      case (func)
        FN_READ, FN_WRITE, FN_ERASE:
          result = prot_hit ? RC_PROT : (stub_fail ? RC_VERIFY : RC_OK);
        FN_PWRITE:
          result = prot_hit ? RC_PROT : (stub_fail ? RC_PCSUM : RC_OK);
        FN_TABLE: result = table_word(blk);
        FN_CSUM:  result = csum_word(key1, key2, blk);
        FN_SWRST: result = RC_SWRST;
        default: begin
          result = RC_FATAL;
          fatal  = 1'b1;
        end
      endcase
    end
  end
endmodule

// File: rtl/svc_call_seq.sv
module svc_call_seq
  import svc_key_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       call,
  input  logic       halted,
  output logic       start,
  output logic       cap_k1,
  output logic       cap_k2,
  output logic       cap_blk,
  output logic [1:0] rd_off,
  output logic       wr_en,
  output logic       done
);
  seq_t st, st_nx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st <= S_IDLE;
    else        st <= st_nx;
  end

  always_comb begin
    st_nx = st;
    case (st)
      S_IDLE:  if (call && !halted) st_nx = S_RK1;
      S_RK1:   st_nx = S_RK2;
      S_RK2:   st_nx = S_RBLK;
      S_RBLK:  st_nx = S_EVAL;
      S_EVAL:  st_nx = S_WRITE;
      S_WRITE: st_nx = S_DONE;
      S_DONE:  st_nx = S_IDLE;
      default: st_nx = S_IDLE;
    endcase
  end

  always_comb begin
    case (st)
      S_RK2:   rd_off = OFF_K2;
      S_RBLK:  rd_off = OFF_BLK;
      default: rd_off = OFF_K1;
    endcase
  end

  assign start   = (st == S_IDLE) && call && !halted;
  assign cap_k1  = (st == S_RK2);
  assign cap_k2  = (st == S_RBLK);
  assign cap_blk = (st == S_EVAL);
  assign wr_en   = (st == S_WRITE);
  assign done    = (st == S_DONE);
endmodule

// File: rtl/svc_key_gate.sv
module svc_key_gate
  import svc_key_pkg::*;
#(
  parameter int             AW    = 8,
  parameter int             NBLK  = 8,
  parameter logic [AW-1:0]  PBASE = 'h40,
  localparam int BLK_W = (NBLK > 1) ? $clog2(NBLK) : 1
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              call_i,
  input  logic [FN_W-1:0]   func_i,
  input  logic [BYTE_W-1:0] sp_i,
  output logic [AW-1:0]     ram_addr_o,
  output logic              ram_we_o,
  output logic [BYTE_W-1:0] ram_wdata_o,
  input  logic [BYTE_W-1:0] ram_rdata_i,
  input  logic [NBLK-1:0]   prot_rd_i,
  input  logic [NBLK-1:0]   prot_wr_i,
  input  logic [NFUNC-1:0]  stub_fail_i,
  output logic              done_o,
  output logic              halted_o
);
  logic [FN_W-1:0]   func_q;
  logic [BYTE_W-1:0] sp_q, k1_q, k2_q, blk_q;
  logic              halted_q;

  logic       start, cap_k1, cap_k2, cap_blk, wr_en, seq_done;
  logic [1:0] rd_off;
  logic       key1_ok, key2_ok, keys_ok;
  logic       guarded, prot_hit, fatal;
  logic [BYTE_W-1:0] result;

  svc_call_seq u_seq (
    .clk(clk), .rst_n(rst_n), .call(call_i), .halted(halted_q),
    .start(start), .cap_k1(cap_k1), .cap_k2(cap_k2), .cap_blk(cap_blk),
    .rd_off(rd_off), .wr_en(wr_en), .done(seq_done)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      func_q   <= '0;
      sp_q     <= '0;
      k1_q     <= '0;
      k2_q     <= '0;
      blk_q    <= '0;
      halted_q <= 1'b0;
    end else begin
      if (start) begin
        func_q <= func_i;
        sp_q   <= sp_i;
      end
      if (cap_k1)  k1_q  <= ram_rdata_i;
      if (cap_k2)  k2_q  <= ram_rdata_i;
      if (cap_blk) blk_q <= ram_rdata_i;
      if (wr_en && fatal) halted_q <= 1'b1;
    end
  end

  svc_key_check u_keys (
    .key1(k1_q), .key2(k2_q), .sp(sp_q),
    .key1_ok(key1_ok), .key2_ok(key2_ok), .keys_ok(keys_ok)
  );

  svc_prot_lookup #(.NBLK(NBLK)) u_prot (
    .idx(blk_q[BLK_W-1:0]), .func(func_q),
    .prot_rd(prot_rd_i), .prot_wr(prot_wr_i),
    .guarded(guarded), .prot_hit(prot_hit)
  );

  svc_dispatch u_disp (
    .keys_ok(keys_ok), .func(func_q), .prot_hit(prot_hit),
    .stub_fail(stub_fail_i[func_q]), .key1(k1_q), .key2(k2_q), .blk(blk_q),
    .result(result), .fatal(fatal)
  );

  assign ram_addr_o  = PBASE + AW'(rd_off);
  assign ram_we_o    = wr_en;
  assign ram_wdata_o = result;
  assign done_o      = seq_done;
  assign halted_o    = halted_q;
endmodule

// File: rtl/svc_key_gate_sva.sv
module svc_key_gate_sva #(
  parameter int            AW    = 8,
  parameter logic [AW-1:0] PBASE = 'h40
)(
  input logic          clk,
  input logic          rst_n,
  input logic          call_i,
  input logic [AW-1:0] ram_addr_o,
  input logic          ram_we_o,
  input logic [7:0]    ram_wdata_o,
  input logic          done_o,
  input logic          halted_o,
  input logic          keys_ok,
  input logic          prot_hit,
  input logic          guarded
);
  assert_write_slot_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we_o |-> ram_addr_o == PBASE);

  assert_done_follows_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we_o |=> done_o);

  assert_done_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  assert_bad_key_fatal_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_we_o && !keys_ok) |-> ram_wdata_o == 8'h03);

  assert_bad_key_halts_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_we_o && !keys_ok) |=> halted_o);

  assert_protect_code_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_we_o && keys_ok && guarded && prot_hit) |-> ram_wdata_o == 8'h01);

  assert_halt_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    halted_o |=> halted_o);

  assert_halt_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (halted_o && call_i) |=> !ram_we_o && !done_o);
endmodule

bind svc_key_gate svc_key_gate_sva #(.AW(AW), .PBASE(PBASE)) u_sva (
  .clk(clk), .rst_n(rst_n), .call_i(call_i),
  .ram_addr_o(ram_addr_o), .ram_we_o(ram_we_o), .ram_wdata_o(ram_wdata_o),
  .done_o(done_o), .halted_o(halted_o),
  .keys_ok(keys_ok), .prot_hit(prot_hit), .guarded(guarded)
);

// File: tb/svc_key_gate_test.sv
module svc_key_gate_test;
  localparam int AW = 8;
  localparam int NBLK = 8;
  localparam logic [7:0] PB = 8'h40;

  logic clk = 1'b0, rst_n = 1'b0, call = 1'b0, ld = 1'b0;
  logic [3:0]  func = '0;
  logic [7:0]  sp = '0;
  logic [7:0]  addr, wdata, rdata = '0;
  logic        we, done, halted;
  logic [7:0]  prd = '0, pwr = '0;
  logic [15:0] sfail = '0;
  logic [7:0]  slot0 = '0, p_k1 = '0, p_k2 = '0, p_blk = '0;

  int checks = 0, fails = 0, writes = 0, dones = 0;
  bit finished = 1'b0;

  typedef struct { logic [7:0] data; logic halt; string tag; } exp_t;
  exp_t sb[$];

  always #10 clk = ~clk;

  svc_key_gate #(.AW(AW), .NBLK(NBLK), .PBASE(PB)) uut (
    .clk(clk), .rst_n(rst_n), .call_i(call), .func_i(func), .sp_i(sp),
    .ram_addr_o(addr), .ram_we_o(we), .ram_wdata_o(wdata), .ram_rdata_i(rdata),
    .prot_rd_i(prd), .prot_wr_i(pwr), .stub_fail_i(sfail),
    .done_o(done), .halted_o(halted)
  );

  // RAM model: only the parameter block is backed
  always @(posedge clk) begin
    if (we && addr == PB) slot0 <= wdata;
    else if (ld)          slot0 <= p_k1;
    if (addr == PB)           rdata <= slot0;
    else if (addr == PB + 1)  rdata <= p_k2;
    else if (addr == PB + 2)  rdata <= p_blk;
    else                      rdata <= 8'h00;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic exp_t model(input logic [3:0] fn, input logic [7:0] s,
                                 input logic [7:0] k1, input logic [7:0] k2,
                                 input logic [7:0] blk, input string tag);
    exp_t e;
    logic pr, pw, f;
    logic [7:0] diff;
    pr = prd[blk[2:0]];
    pw = pwr[blk[2:0]];
    f  = sfail[fn];
    diff = k2 - s;
    e.tag = tag;
    e.halt = 1'b0;
    if (k1 != 8'h3A || diff != 8'd3) begin
      e.data = 8'h03; e.halt = 1'b1;
    end else begin
      case (fn)
        4'd1:       e.data = pr ? 8'h01 : (f ? 8'h04 : 8'h00);
        4'd2, 4'd3: e.data = pw ? 8'h01 : (f ? 8'h04 : 8'h00);
        4'd4:       e.data = pw ? 8'h01 : (f ? 8'h06 : 8'h00);
        4'd5:       e.data = {~blk[7], blk[6], ~blk[5], blk[4], blk[3], ~blk[2], blk[1], ~blk[0]};
        4'd6:       e.data = k1 + k2 + blk;
        4'd7:       e.data = 8'h02;
        default: begin e.data = 8'h03; e.halt = 1'b1; end
      endcase
    end
    return e;
  endfunction

  // monitor: compare writes and done against the scoreboard
  always @(negedge clk) begin
    if (rst_n) begin
      if (we) begin
        writes++;
        if (sb.size() == 0) check(1'b0, "R3 unexpected write", wdata, 0);
        else begin
          check(addr == PB, {sb[0].tag, " R3 address"}, addr, PB);
          check(wdata == sb[0].data, sb[0].tag, wdata, sb[0].data);
        end
      end
      if (done) begin
        dones++;
        if (sb.size() == 0) check(1'b0, "R10 unexpected done", 1, 0);
        else begin
          exp_t e;
          e = sb.pop_front();
          check(halted == e.halt, {e.tag, " halt flag"}, halted, e.halt);
        end
      end
    end
  end

  task automatic do_reset();
    rst_n = 1'b0;
    sb.delete();
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic do_call(input logic [3:0] fn, input logic [7:0] s, input logic [7:0] k1,
                         input logic [7:0] k2, input logic [7:0] blk, input string tag,
                         input bit extra_pulse);
    exp_t e;
    int n, w0, d0;
    p_k1 = k1; p_k2 = k2; p_blk = blk;
    ld = 1'b1; @(negedge clk); ld = 1'b0;
    e = model(fn, s, k1, k2, blk, tag);
    sb.push_back(e);
    w0 = writes; d0 = dones;
    func = fn; sp = s; call = 1'b1;
    @(negedge clk);
    call = 1'b0;
    if (extra_pulse) begin
      @(negedge clk); call = 1'b1; @(negedge clk); call = 1'b0;
    end
    n = 0;
    while (!done && n < 40) begin @(negedge clk); n++; end
    check(done == 1'b1, {tag, " R10 done seen"}, done, 1);
    @(negedge clk);
    check(done == 1'b0, {tag, " R10 done one cycle"}, done, 0);
    check(slot0 == e.data, {tag, " R3 slot readback"}, slot0, e.data);
    repeat (3) @(negedge clk);
    check(writes - w0 == 1, {tag, " R3 one write"}, writes - w0, 1);
    check(dones - d0 == 1, {tag, " R10 one done"}, dones - d0, 1);
  endtask

  initial begin
    repeat (2) @(negedge clk);
    check(done == 1'b0, "R11 done at reset", done, 0);
    check(we == 1'b0, "R11 we at reset", we, 0);
    check(halted == 1'b0, "R11 halted at reset", halted, 0);
    rst_n = 1'b1;
    @(negedge clk);

    prd = 8'b0000_0100;   // block 2 read-protected
    pwr = 8'b0010_0000;   // block 5 write-protected
    sfail = 16'h0000;
    do_call(4'd1, 8'h20, 8'h3A, 8'h23, 8'h01, "R5 read pass", 1'b0);
    do_call(4'd1, 8'h20, 8'h3A, 8'h23, 8'h02, "R4 read protected", 1'b0);
    do_call(4'd1, 8'h20, 8'h3A, 8'h23, 8'h05, "R4 read ignores wr bit", 1'b0);
    do_call(4'd2, 8'h10, 8'h3A, 8'h13, 8'h0D, "R4 write protected via low bits", 1'b0);
    do_call(4'd3, 8'h10, 8'h3A, 8'h13, 8'h02, "R4 erase ignores rd bit", 1'b0);
    sfail = 16'b0000_0000_0001_1010;
    do_call(4'd3, 8'h10, 8'h3A, 8'h13, 8'h03, "R5 erase fail", 1'b0);
    do_call(4'd1, 8'h10, 8'h3A, 8'h13, 8'h03, "R5 read fail", 1'b0);
    do_call(4'd4, 8'h10, 8'h3A, 8'h13, 8'h03, "R5 param write fail", 1'b0);
    do_call(4'd4, 8'h10, 8'h3A, 8'h13, 8'h05, "R4 param write protected", 1'b0);
    sfail = 16'h0000;
    do_call(4'd4, 8'h10, 8'h3A, 8'h13, 8'h03, "R5 param write pass", 1'b0);
    do_call(4'd5, 8'h80, 8'h3A, 8'h83, 8'h3C, "R7 table read", 1'b0);
    do_call(4'd6, 8'h80, 8'h3A, 8'h83, 8'hF7, "R7 checksum", 1'b0);
    do_call(4'd7, 8'h00, 8'h3A, 8'h03, 8'h00, "R6 soft reset", 1'b0);
    do_call(4'd1, 8'hFE, 8'h3A, 8'h01, 8'h00, "R2 stack wrap", 1'b0);
    do_call(4'd7, 8'h44, 8'h3A, 8'h47, 8'h00, "R10 busy call ignored", 1'b1);

    do_call(4'd1, 8'h20, 8'h3A, 8'h24, 8'h00, "R2 bad key2", 1'b0);
    check(halted == 1'b1, "R2 halted after bad key2", halted, 1);
    do_reset();
    check(halted == 1'b0, "R11 halted cleared", halted, 0);

    do_call(4'd7, 8'h20, 8'h3B, 8'h23, 8'h00, "R1 bad key1", 1'b0);
    begin
      int w0, d0;
      w0 = writes; d0 = dones;
      p_k1 = 8'h3A; p_k2 = 8'h23;
      func = 4'd7; sp = 8'h20; call = 1'b1;
      repeat (3) @(negedge clk);
      call = 1'b0;
      repeat (20) @(negedge clk);
      check(writes == w0, "R9 no write while halted", writes - w0, 0);
      check(dones == d0, "R9 no done while halted", dones - d0, 0);
      check(halted == 1'b1, "R9 halt holds", halted, 1);
    end
    do_reset();

    do_call(4'd0, 8'h20, 8'h3A, 8'h23, 8'h00, "R8 code 0 fatal", 1'b0);
    do_reset();
    do_call(4'd12, 8'h20, 8'h3A, 8'h23, 8'h00, "R8 code 12 fatal", 1'b0);
    do_reset();

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule